// File: doc/BRIEF.md
# Timer Compare Unit with Match Actions

This block watches a free-running timer value supplied from outside and compares it with a programmed compare value. When the two become equal, it carries out one action chosen by a four-bit mode code. It can toggle, set or clear a single output pin, or only raise the interrupt. It can also fire a special event, which asks the timer owner to clear the timer and, if the converter is enabled, asks an ADC to start a conversion. The timer counter, the converter and any register bus stay outside the block.

A match counts once for each time the timer arrives at the compare value. A timer that stops on the compare value therefore causes one action, not one per clock. Codes that are not compare codes switch the unit off. While off, the pin is held low and nothing fires. Entering set-on-match mode starts the pin low, and entering clear-on-match mode starts it high, so that the first match always produces a visible edge.

Top module: `cmp_action_unit`

## Requirements
- R1: With mode code 4'b0010, a match inverts `outPin` and pulses `irqFlag`.
- R2: With mode code 4'b1000, a match drives `outPin` to 1 and pulses `irqFlag`.
- R3: With mode code 4'b1001, a match drives `outPin` to 0 and pulses `irqFlag`.
- R4: With mode code 4'b1010, a match pulses `irqFlag` and `outPin` keeps its value.
- R5: With mode code 4'b1011, a match pulses `irqFlag` and `timerClear`. It also pulses `adcStart` when `adcEnable` was 1 in the matching cycle, and does not pulse it otherwise.
- R6: Mode code 4'b0000, and every code other than 0010, 1000, 1001, 1010 and 1011, holds `outPin` at 0, keeps all pulses at 0 and forgets any earlier match.
- R7: A match is the first cycle in which `timerValue` equals `cmpValue` while in a compare mode. A timer that stays on the compare value, including across a switch between compare modes, causes no further action until it has left that value.
- R8: On the first cycle in code 1000, `outPin` is loaded with 0, and on the first cycle in code 1001 it is loaded with 1. A match in that same cycle overrides the load.
- R9: All outputs are registered and change one clock after the matching input cycle. `irqFlag`, `timerClear` and `adcStart` are single-cycle pulses.
- R10: An active-low reset drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 4 | Action mode code |
| cmpValue | input | 16 | Compare value |
| timerValue | input | 16 | Current timer count |
| adcEnable | input | 1 | Converter enabled; gates the start request |
| outPin | output | 1 | Compare output pin |
| irqFlag | output | 1 | Interrupt pulse on a match |
| timerClear | output | 1 | Request to clear the timer (special event) |
| adcStart | output | 1 | Request to start a conversion (special event) |

## Verification
Two things can happen in the same cycle: the first cycle of a new mode, which loads the pin with its starting level, and a match, which applies the action. The bench provokes this by going from an inactive code straight into set-on-match while the timer already equals the compare value. The pin must end high, and the interrupt must pulse. The opposite case is also tested: the bench switches into clear-on-match while the match from the previous mode is still held. Here only the starting level may appear, with no pulse.

// File: rtl/cmp_action_pkg.sv
package cmp_action_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF    = 4'b0000,
    MODE_TOGGLE = 4'b0010,
    MODE_SET    = 4'b1000,
    MODE_CLEAR  = 4'b1001,
    MODE_IRQ    = 4'b1010,
    MODE_EVENT  = 4'b1011
  } cmpMode_e;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic pinLoad;     // load pinValue into the output pin
    logic pinValue;
    logic pinToggle;   // invert the output pin
    logic irqPulse;
    logic eventPulse;  // timer clear request
    logic adcPulse;    // conversion start request
    logic disarm;      // forget the previous compare state
  } ctrlStrobes_t;

endpackage

// File: rtl/cmp_action_ctrl.sv
module cmp_action_ctrl
  import cmp_action_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              matchHit,
  input  logic              adcEnable,
  output ctrlStrobes_t      strobes
);

  logic [MODE_W-1:0] modeLast;
  logic              wasActive;
  logic              active;
  logic              entry;
  logic              fire;

  always_comb begin
    active = (modeSel == MODE_TOGGLE) || (modeSel == MODE_SET) ||
             (modeSel == MODE_CLEAR)  || (modeSel == MODE_IRQ) ||
             (modeSel == MODE_EVENT);
    entry  = active && (!wasActive || (modeSel != modeLast));
    fire   = active && matchHit;
  end

  always_comb begin
    strobes        = '0;
    strobes.disarm = !active;
    if (!active) begin
      strobes.pinLoad  = 1'b1;
      strobes.pinValue = 1'b0;
    end else begin
      // starting level on mode entry (R8)
      if (entry && modeSel == MODE_SET) begin
        strobes.pinLoad  = 1'b1;
        strobes.pinValue = 1'b0;
      end
      if (entry && modeSel == MODE_CLEAR) begin
        strobes.pinLoad  = 1'b1;
        strobes.pinValue = 1'b1;
      end
      // match action overrides the entry load
      if (fire) begin
        strobes.irqPulse = 1'b1;
        case (modeSel)
          MODE_TOGGLE: strobes.pinToggle = 1'b1;
          MODE_SET: begin
            strobes.pinLoad  = 1'b1;
            strobes.pinValue = 1'b1;
          end
          MODE_CLEAR: begin
            strobes.pinLoad  = 1'b1;
            strobes.pinValue = 1'b0;
          end
          MODE_EVENT: begin
            strobes.eventPulse = 1'b1;
            strobes.adcPulse   = adcEnable;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeLast  <= MODE_OFF;
      wasActive <= 1'b0;
    end else begin
      modeLast  <= modeSel;
      wasActive <= active;
    end
  end

endmodule

// File: rtl/cmp_action_dp.sv
module cmp_action_dp
  import cmp_action_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIMER_W-1:0] timerValue,
  input  logic [TIMER_W-1:0] cmpValue,
  input  ctrlStrobes_t       strobes,
  output logic               matchHit,
  output logic               outPin,
  output logic               irqFlag,
  output logic               timerClear,
  output logic               adcStart
);

  logic eqNow;
  logic eqPrev;

  always_comb begin
    eqNow    = (timerValue == cmpValue);
    matchHit = eqNow && !eqPrev;  // one action per arrival (R7)
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eqPrev     <= 1'b0;
      outPin     <= 1'b0;
      irqFlag    <= 1'b0;
      timerClear <= 1'b0;
      adcStart   <= 1'b0;
    end else begin
      eqPrev <= strobes.disarm ? 1'b0 : eqNow;
      if (strobes.pinLoad) begin
        outPin <= strobes.pinValue;
      end else if (strobes.pinToggle) begin
        outPin <= ~outPin;
      end
      irqFlag    <= strobes.irqPulse;
      timerClear <= strobes.eventPulse;
      adcStart   <= strobes.adcPulse;
    end
  end

endmodule

// File: rtl/cmp_action_unit.sv
module cmp_action_unit
  import cmp_action_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [MODE_W-1:0]  modeSel,
  input  logic [TIMER_W-1:0] cmpValue,
  input  logic [TIMER_W-1:0] timerValue,
  input  logic               adcEnable,
  output logic               outPin,
  output logic               irqFlag,
  output logic               timerClear,
  output logic               adcStart
);

  ctrlStrobes_t strobes;
  logic         matchHit;

  cmp_action_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .matchHit  (matchHit),
    .adcEnable (adcEnable),
    .strobes   (strobes)
  );

  cmp_action_dp #(.TIMER_W(TIMER_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .timerValue (timerValue),
    .cmpValue   (cmpValue),
    .strobes    (strobes),
    .matchHit   (matchHit),
    .outPin     (outPin),
    .irqFlag    (irqFlag),
    .timerClear (timerClear),
    .adcStart   (adcStart)
  );

endmodule

// File: rtl/cmp_action_checker.sv
module cmp_action_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] modeSel,
  input logic       adcEnable,
  input logic       outPin,
  input logic       irqFlag,
  input logic       timerClear,
  input logic       adcStart
);

  p_adc_with_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> timerClear);

  p_adc_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> $past(adcEnable));

  p_event_irq_r5: assert property (@(posedge clk) disable iff (!rstN)
    timerClear |-> irqFlag);

  p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 4'b0000) |=> (!outPin && !irqFlag && !timerClear));

  p_irq_pin_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 4'b1010) |=> $stable(outPin));

  p_clear_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    timerClear |=> !timerClear);

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag |=> !irqFlag);

endmodule

bind cmp_action_unit cmp_action_checker uChecker (
  .clk        (clk),
  .rstN       (rstN),
  .modeSel    (modeSel),
  .adcEnable  (adcEnable),
  .outPin     (outPin),
  .irqFlag    (irqFlag),
  .timerClear (timerClear),
  .adcStart   (adcStart)
);

// File: tb/tb_cmp_action_unit.sv
module tb_cmp_action_unit;

  typedef struct packed {
    logic [3:0]  mode;
    logic [15:0] tmr;
    logic [15:0] cmp;
    logic        adc;
    logic        ePin;
    logic        eIrq;
    logic        eClr;
    logic        eAdc;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 24;
  // Expected values follow the requirements; rows carry state forward
  localparam vec_t VEC [NVEC] = '{
    '{4'b0000, 16'd5, 16'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 off
    '{4'b0010, 16'd4, 16'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1},
    '{4'b0010, 16'd5, 16'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1},  // R1 toggle
    '{4'b0010, 16'd5, 16'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 held
    '{4'b0010, 16'd6, 16'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1},
    '{4'b0010, 16'd5, 16'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1},  // R1 again
    '{4'b1000, 16'd7, 16'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 entry low
    '{4'b1000, 16'd5, 16'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 set
    '{4'b1000, 16'd6, 16'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},
    '{4'b1001, 16'd6, 16'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 entry high
    '{4'b1001, 16'd5, 16'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 clear
    '{4'b1010, 16'd9, 16'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},
    '{4'b1010, 16'd5, 16'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 irq only
    '{4'b0010, 16'd5, 16'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 mode swap
    '{4'b1011, 16'd3, 16'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},
    '{4'b1011, 16'd5, 16'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd5},  // R5 event+adc
    '{4'b1011, 16'd5, 16'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 single
    '{4'b1011, 16'd0, 16'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},
    '{4'b1011, 16'd5, 16'd5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 adc off
    '{4'b1001, 16'd0, 16'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8},
    '{4'b0000, 16'd0, 16'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 pin low
    '{4'b0101, 16'd5, 16'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 other code
    '{4'b1000, 16'd5, 16'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 entry+match
    '{4'b1001, 16'd5, 16'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8}   // R8/R7 held
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  modeSel = 4'b0000;
  logic [15:0] cmpValue = '0;
  logic [15:0] timerValue = '0;
  logic        adcEnable = 1'b0;
  logic        outPin, irqFlag, timerClear, adcStart;

  int  testsRun = 0;
  int  testsFailed = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  cmp_action_unit dut (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .cmpValue   (cmpValue),
    .timerValue (timerValue),
    .adcEnable  (adcEnable),
    .outPin     (outPin),
    .irqFlag    (irqFlag),
    .timerClear (timerClear),
    .adcStart   (adcStart)
  );

  task automatic checkOut(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {outPin, irqFlag, timerClear, adcStart};
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s pin/irq/clr/adc actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkOut("R10 reset", 4'b0000);  // R10
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      modeSel    = VEC[i].mode;
      timerValue = VEC[i].tmr;
      cmpValue   = VEC[i].cmp;
      adcEnable  = VEC[i].adc;
      @(posedge clk);
      #1;
      checkOut($sformatf("R%0d row%0d", VEC[i].req, i),
               {VEC[i].ePin, VEC[i].eIrq, VEC[i].eClr, VEC[i].eAdc});
    end
    // R9: no output moves before the clock edge after a match is applied
    @(negedge clk);
    modeSel = 4'b1011; timerValue = 16'd1; cmpValue = 16'd2; adcEnable = 1'b1;
    @(negedge clk);
    timerValue = 16'd2;
    #1;
    checkOut("R9 before edge", 4'b1000);
    @(posedge clk);
    #1;
    checkOut("R9 after edge", 4'b1111);
    // R10: reset in mid-run with the pin high
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkOut("R10 mid-run reset", 4'b0000);
    @(negedge clk);
    rstN = 1'b1;
    modeSel = 4'b0000;
    @(posedge clk);
    #1;
    checkOut("R6 after reset", 4'b0000);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule